// File: doc/BRIEF.md
# Link frame encoder with byte gearbox

This block packs a 20-bit payload word, a 2-bit flag field and a data-available qualifier into a 24-bit link frame once per word-clock cycle. It then hands the frame out as three bytes on an 8-bit bus running at exactly three times the word clock, ready for a serial transceiver running at 960 Mb/s. When the qualifier is low, an idle frame is sent in place of a data frame. While a lane is held in reset, and until its first frame after release is ready, the lane sends zero bytes.

The word clock and the fast clock are phase-locked inputs. Word clock rising edges coincide with every third fast clock rising edge. The block holds a configurable number of independent lanes, two by default, for a readout stream and a region-of-interest stream. Each lane has its own reset bit. In the fast domain, a byte counter is realigned to each word-clock edge, so a frame is never split across two word periods.

Top module: `lfe_link_tx`

## Requirements
- R1: When `dav_i` is 1 at a word-clock edge, the lane's next frame is {2'b01, flag, data}: bits 23:22 hold header 01, bits 21:20 hold the flag field and bits 19:0 hold the payload sampled at that edge.
- R2: When `dav_i` is 0 at a word-clock edge, the lane's next frame is the idle frame 24'h800000 (header 10, all other bits zero), and the flag and data inputs have no effect on it.
- R3: A frame sampled at a word-clock edge goes out on `byte_o` in the three fast cycles that follow that edge, most significant byte first (bits 23:16, then 15:8, then 7:0). Loads into the fast domain are exactly three fast cycles apart, so a frame is never split.
- R4: While a lane's `rst_ni` bit is 0, that lane's `byte_o` is 8'h00.
- R5: After a lane's reset is released, its `byte_o` stays 8'h00 until the first byte of the frame sampled at the first word-clock edge after release.
- R6: Resetting one lane leaves the byte stream of every other lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_word_i | input | 1 | Word clock (40 MHz), phase-locked to clk_fast_i |
| clk_fast_i | input | 1 | Byte clock (120 MHz), three times the word clock |
| rst_ni | input | NUM_LANES | Active-low asynchronous reset, one bit per lane |
| dav_i | input | NUM_LANES | Data-available qualifier per lane |
| flag_i | input | NUM_LANES*FLAG_W | Flag field per lane, lane l at [l*FLAG_W +: FLAG_W] |
| data_i | input | NUM_LANES*WORD_W | Payload per lane, lane l at [l*WORD_W +: WORD_W] |
| byte_o | output | NUM_LANES*BYTE_W | Output byte per lane, lane l at [l*BYTE_W +: BYTE_W] |

## Verification
Runs of random payloads with `dav_i` held high show where the header, flag and data bits land and in what byte order. A run with `dav_i` held low while flag and data keep changing shows that idle frames ignore those inputs. Random `dav_i` interleaving shows that the frame type switches cleanly on every word period. The inputs also change on every fast cycle, which exposes any sampling away from the word edge. Reset of one lane alone, and a release placed off the word edge, show lane independence and the zero stream up to the first aligned frame.

// File: rtl/lfe_pkg.sv
package lfe_pkg;
  localparam int unsigned HDR_W       = 2;
  localparam logic [1:0]  HDR_DATA    = 2'b01;
  localparam logic [1:0]  HDR_IDLE    = 2'b10;
  localparam int unsigned DEF_WORD_W  = 20;
  localparam int unsigned DEF_FLAG_W  = 2;
  localparam int unsigned DEF_BYTE_W  = 8;
endpackage

// File: rtl/lfe_word_enc.sv
module lfe_word_enc
  import lfe_pkg::*;
#(
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned FLAG_W  = DEF_FLAG_W,
  localparam int unsigned FRAME_W = HDR_W + FLAG_W + WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dav_i,
  input  logic [FLAG_W-1:0]  flag_i,
  input  logic [WORD_W-1:0]  data_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               tgl_o
);
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    if (dav_i) frame_d = {HDR_DATA, flag_i, data_i};
    else       frame_d = {HDR_IDLE, {(FRAME_W-HDR_W){1'b0}}};
  end

  // tgl_o flips once per word period; the fast domain spots the change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      tgl_o   <= 1'b0;
    end else begin
      frame_o <= frame_d;
      tgl_o   <= ~tgl_o;
    end
  end
endmodule

// File: rtl/lfe_phase_trk.sv
module lfe_phase_trk #(
  parameter int unsigned NBYTES = 3,
  localparam int unsigned PH_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic load_o
);
  logic            tgl_q;
  logic            synced_q;
  logic [PH_W-1:0] phase_q;
  logic            word_edge;

  assign word_edge = tgl_i ^ tgl_q;
  // free-run only after the first word edge; the edge always wins
  assign load_o = word_edge | (synced_q & (phase_q == PH_W'(NBYTES-1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q    <= 1'b0;
      synced_q <= 1'b0;
      phase_q  <= '0;
    end else begin
      tgl_q    <= tgl_i;
      synced_q <= synced_q | word_edge;
      phase_q  <= load_o ? '0 : phase_q + PH_W'(1);
    end
  end
endmodule

// File: rtl/lfe_byte_mux.sv
module lfe_byte_mux #(
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [BYTE_W-1:0]  byte_o
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= frame_i;
    else             sh_q <= {sh_q[FRAME_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
  end

  assign byte_o = sh_q[FRAME_W-1 -: BYTE_W];
endmodule

// File: rtl/lfe_link_tx.sv
module lfe_link_tx
  import lfe_pkg::*;
#(
  parameter int unsigned NUM_LANES = 2,
  parameter int unsigned WORD_W    = DEF_WORD_W,
  parameter int unsigned FLAG_W    = DEF_FLAG_W,
  parameter int unsigned BYTE_W    = DEF_BYTE_W,
  localparam int unsigned FRAME_W  = HDR_W + FLAG_W + WORD_W,
  localparam int unsigned NBYTES   = FRAME_W / BYTE_W
) (
  input  logic                          clk_word_i,
  input  logic                          clk_fast_i,
  input  logic [NUM_LANES-1:0]          rst_ni,
  input  logic [NUM_LANES-1:0]          dav_i,
  input  logic [NUM_LANES*FLAG_W-1:0]   flag_i,
  input  logic [NUM_LANES*WORD_W-1:0]   data_i,
  output logic [NUM_LANES*BYTE_W-1:0]   byte_o
);
  logic [NUM_LANES-1:0]         tgl_w;
  logic [NUM_LANES-1:0]         load_w;
  logic [NUM_LANES*FRAME_W-1:0] frame_w;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    lfe_word_enc #(
      .WORD_W (WORD_W),
      .FLAG_W (FLAG_W)
    ) u_enc (
      .clk_i   (clk_word_i),
      .rst_ni  (rst_ni[l]),
      .dav_i   (dav_i[l]),
      .flag_i  (flag_i[l*FLAG_W +: FLAG_W]),
      .data_i  (data_i[l*WORD_W +: WORD_W]),
      .frame_o (frame_w[l*FRAME_W +: FRAME_W]),
      .tgl_o   (tgl_w[l])
    );

    lfe_phase_trk #(
      .NBYTES (NBYTES)
    ) u_trk (
      .clk_i  (clk_fast_i),
      .rst_ni (rst_ni[l]),
      .tgl_i  (tgl_w[l]),
      .load_o (load_w[l])
    );

    lfe_byte_mux #(
      .FRAME_W (FRAME_W),
      .BYTE_W  (BYTE_W)
    ) u_mux (
      .clk_i   (clk_fast_i),
      .rst_ni  (rst_ni[l]),
      .load_i  (load_w[l]),
      .frame_i (frame_w[l*FRAME_W +: FRAME_W]),
      .byte_o  (byte_o[l*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/lfe_link_tx_chk.sv
module lfe_link_tx_chk
  import lfe_pkg::*;
#(
  parameter int unsigned NUM_LANES = 2,
  parameter int unsigned WORD_W    = DEF_WORD_W,
  parameter int unsigned FLAG_W    = DEF_FLAG_W,
  parameter int unsigned BYTE_W    = DEF_BYTE_W,
  localparam int unsigned FRAME_W  = HDR_W + FLAG_W + WORD_W
) (
  input logic                          clk_word_i,
  input logic                          clk_fast_i,
  input logic [NUM_LANES-1:0]          rst_ni,
  input logic [NUM_LANES-1:0]          dav_i,
  input logic [NUM_LANES*WORD_W-1:0]   data_i,
  input logic [NUM_LANES*BYTE_W-1:0]   byte_o,
  input logic [NUM_LANES-1:0]          load_w,
  input logic [NUM_LANES*FRAME_W-1:0]  frame_w
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
    assert_data_frame_R1: assert property (@(posedge clk_word_i) disable iff (!rst_ni[l])
      dav_i[l] |=> (frame_w[l*FRAME_W+FRAME_W-1 -: HDR_W] == HDR_DATA) &&
                   (frame_w[l*FRAME_W +: WORD_W] == $past(data_i[l*WORD_W +: WORD_W])));

    assert_idle_frame_R2: assert property (@(posedge clk_word_i) disable iff (!rst_ni[l])
      !dav_i[l] |=> frame_w[l*FRAME_W +: FRAME_W] == {HDR_IDLE, {(FRAME_W-HDR_W){1'b0}}});

    assert_first_byte_R3: assert property (@(posedge clk_fast_i) disable iff (!rst_ni[l])
      load_w[l] |=> byte_o[l*BYTE_W +: BYTE_W] ==
                    $past(frame_w[l*FRAME_W+FRAME_W-1 -: BYTE_W]));

    assert_second_byte_R3: assert property (@(posedge clk_fast_i) disable iff (!rst_ni[l])
      load_w[l] |=> ##1 byte_o[l*BYTE_W +: BYTE_W] ==
                    $past(frame_w[l*FRAME_W+FRAME_W-BYTE_W-1 -: BYTE_W], 2));

    assert_no_split_a_R3: assert property (@(posedge clk_fast_i) disable iff (!rst_ni[l])
      load_w[l] |=> !load_w[l]);

    assert_no_split_b_R3: assert property (@(posedge clk_fast_i) disable iff (!rst_ni[l])
      load_w[l] |=> ##1 !load_w[l]);

    always @(negedge clk_fast_i) begin
      if (!rst_ni[l]) begin
        assert_reset_zero_R4: assert (byte_o[l*BYTE_W +: BYTE_W] == '0);
      end
    end
  end
endmodule

bind lfe_link_tx lfe_link_tx_chk #(
  .NUM_LANES (NUM_LANES),
  .WORD_W    (WORD_W),
  .FLAG_W    (FLAG_W),
  .BYTE_W    (BYTE_W)
) u_chk (
  .clk_word_i (clk_word_i),
  .clk_fast_i (clk_fast_i),
  .rst_ni     (rst_ni),
  .dav_i      (dav_i),
  .data_i     (data_i),
  .byte_o     (byte_o),
  .load_w     (load_w),
  .frame_w    (frame_w)
);

// File: tb/lfe_link_tx_tb.sv
module lfe_link_tx_tb;
  localparam int NL = 2;

  logic          clk_w = 1'b0;
  logic          clk_f = 1'b0;
  logic [NL-1:0] rst_n = '0;
  logic [NL-1:0] dav   = '0;
  logic [2*NL-1:0]  flag = '0;
  logic [20*NL-1:0] data = '0;
  logic [8*NL-1:0]  byte_o;

  int ph = 0;
  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit chk_en  = 1'b0;
  bit done    = 1'b0;
  string cur_req = "R4";

  logic [7:0] exp_q [NL][$];
  logic [7:0] exp_b [NL];

  lfe_link_tx #(.NUM_LANES(NL)) u_dut (
    .clk_word_i (clk_w),
    .clk_fast_i (clk_f),
    .rst_ni     (rst_n),
    .dav_i      (dav),
    .flag_i     (flag),
    .data_i     (data),
    .byte_o     (byte_o)
  );

  // 50 MHz fast clock; word clock rises on every third fast edge
  initial begin
    forever begin
      #10;
      if (ph == 0) clk_w = 1'b1;
      clk_f = 1'b1;
      #10;
      clk_f = 1'b0;
      if (ph == 1) clk_w = 1'b0;
      ph = (ph + 1) % 3;
    end
  end

  function automatic logic [23:0] frame_of(logic v, logic [1:0] f, logic [19:0] d);
    return v ? {2'b01, f, d} : 24'h800000;
  endfunction

  // reference model: byte due in the fast cycle after each edge
  always @(posedge clk_f) begin
    for (int l = 0; l < NL; l++) begin
      if (!rst_n[l]) begin
        exp_q[l].delete();
        exp_b[l] = 8'h00;
      end else begin
        exp_b[l] = (exp_q[l].size() > 0) ? exp_q[l].pop_front() : 8'h00;
        if (ph == 0) begin
          logic [23:0] fr;
          fr = frame_of(dav[l], flag[l*2 +: 2], data[l*20 +: 20]);
          exp_q[l].push_back(fr[23:16]);
          exp_q[l].push_back(fr[15:8]);
          exp_q[l].push_back(fr[7:0]);
        end
      end
    end
  end

  always @(negedge clk_f) begin
    cyc++;
    if (chk_en) begin
      for (int l = 0; l < NL; l++) begin
        n_tests++;
        if (byte_o[l*8 +: 8] !== exp_b[l]) begin
          n_fail++;
          $display("FAIL %s lane %0d cycle %0d: byte got %h exp %h",
                   cur_req, l, cyc, byte_o[l*8 +: 8], exp_b[l]);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk_f);
    #2;
  endtask

  task automatic check_byte(string req, int l, logic [7:0] e);
    n_tests++;
    if (byte_o[l*8 +: 8] !== e) begin
      n_fail++;
      $display("FAIL %s lane %0d: byte got %h exp %h", req, l, byte_o[l*8 +: 8], e);
    end
  endtask

  task automatic drive_rand(int n_fast, int dav_mode);
    for (int i = 0; i < n_fast; i++) begin
      for (int l = 0; l < NL; l++) begin
        dav[l] = (dav_mode == 2) ? 1'($urandom) : dav_mode[0];
        flag[l*2 +: 2]  = 2'($urandom);
        data[l*20 +: 20] = 20'($urandom);
      end
      step(1);
    end
  endtask

  task automatic drive_const(int n_fast, logic v, logic [1:0] f, logic [19:0] d);
    for (int l = 0; l < NL; l++) begin
      dav[l] = v;
      flag[l*2 +: 2] = f;
      data[l*20 +: 20] = d;
    end
    step(n_fast);
  endtask

  initial begin
    step(1);
    chk_en = 1'b1;
    cur_req = "R4";
    step(6);
    check_byte("R4", 0, 8'h00);
    check_byte("R4", 1, 8'h00);

    // release off the word edge; zeros until first aligned frame
    cur_req = "R5";
    while (ph != 1) step(1);
    rst_n = '1;
    check_byte("R5", 0, 8'h00);
    check_byte("R5", 1, 8'h00);
    drive_const(9, 1'b1, 2'b11, 20'hFFFFF);

    cur_req = "R1";
    drive_rand(120, 1);
    drive_const(6, 1'b1, 2'b01, 20'hA5A5A);
    drive_const(6, 1'b1, 2'b10, 20'h00001);

    cur_req = "R2";
    drive_rand(90, 0);
    drive_const(6, 1'b0, 2'b11, 20'hFFFFF);

    cur_req = "R3";
    drive_rand(300, 2);

    // reset lane 0 alone while lane 1 keeps running
    cur_req = "R6";
    rst_n[0] = 1'b0;
    drive_rand(30, 2);
    check_byte("R6", 0, 8'h00);
    rst_n[0] = 1'b1;
    drive_rand(30, 2);
    rst_n[1] = 1'b0;
    drive_rand(20, 2);
    check_byte("R6", 1, 8'h00);
    while (ph != 2) step(1);
    cur_req = "R5";
    rst_n[1] = 1'b1;
    drive_rand(40, 2);

    chk_en = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_f);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule